// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the architectural registers of a 32-bit processor core whose visible register set changes with the operating mode. The core presents a 4-bit register index and the current 5-bit mode. The block maps that pair onto one of 31 physical general-purpose entries and performs the access. Two read ports are combinational. The single write port commits on the rising clock edge.

The block also keeps the current status word and five saved status words. Each exception mode owns one saved status word. The fast-interrupt mode owns private copies of registers 8 to 14. The supervisor, abort, normal-interrupt and undefined modes each own private copies of registers 13 and 14. User and system modes share one plain set.

A user-bank override input lets privileged code reach the user copies of the banked registers. Instruction decode, flag generation and exception sequencing are left to the surrounding core.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-low reset clears every general-purpose entry and every saved status word. It loads the current status word with 0x000000D3: mode field bits [4:0] = 10011, normal-interrupt disable at bit 7 and fast-interrupt disable at bit 6.
- R2: Index 15 (program counter) is one physical register shared by every mode.
- R3: Indices 0 to 7 are one physical set shared by every mode.
- R4: In fast-interrupt mode, indices 8 to 12 select a private set. Every other mode shares a single copy of indices 8 to 12.
- R5: Fast-interrupt, supervisor, abort, normal-interrupt and undefined modes each have private copies of index 13 and index 14. User and system modes share the same copies.
- R6: When the user-bank input is 1 in a privileged mode, both read ports and the write port use the user copies of indices 8 to 14. The private copies are left unchanged.
- R7: Each of the five exception modes has its own saved status word, written and read through dedicated ports selected by the mode input. In user or system mode a saved-status write changes no storage, and the saved-status read returns 0.
- R8: A general-purpose write becomes visible on the next cycle. A read of the same physical entry in the write cycle returns the old value. Both read ports resolve their indices independently.
- R9: A current-status write becomes visible on the output in the next cycle.
- R10: Mode encodings are user 10000, fast-interrupt 10001, normal-interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. Any other encoding behaves as user mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 5 | Current operating mode |
| user_bank_i | input | 1 | Force user copies of banked registers |
| rd_a_idx_i | input | 4 | Read port A index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General-purpose write enable |
| wr_idx_i | input | 4 | Write index |
| wr_data_i | input | 32 | Write data |
| cpsr_wr_en_i | input | 1 | Current status write enable |
| cpsr_wr_data_i | input | 32 | Current status write data |
| cpsr_o | output | 32 | Current status word |
| spsr_wr_en_i | input | 1 | Saved status write enable |
| spsr_wr_data_i | input | 32 | Saved status write data |
| spsr_rd_data_o | output | 32 | Saved status word of the current mode |

## Verification
The bench builds the block with its default 32-bit data width and two read ports. Every banking case is then reachable with ordinary values. The bench writes a distinct pattern through one mode and reads it back through every other mode. This exposes any wrong mapping between index, mode and physical entry. The same-cycle write-and-read case and the user-bank override are both driven on the second read port as well.

// File: rtl/bankreg_pkg.sv
// Shared definitions for the mode-banked register file.
// Assumes a 5-bit mode field and 16 architectural indices.
package bankreg_pkg;

    localparam int IDX_W  = 4;
    localparam int MODE_W = 5;

    // Mode encodings seen on the mode input.
    localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

    // Register bank selected by a mode; user covers system and unknown codes.
    typedef enum logic [2:0] {
        BANK_USR = 3'd0,
        BANK_FIQ = 3'd1,
        BANK_SVC = 3'd2,
        BANK_ABT = 3'd3,
        BANK_IRQ = 3'd4,
        BANK_UND = 3'd5
    } bank_e;

    localparam int NUM_SAVED = 5;   // one saved status word per exception bank

    // Physical layout of the general-purpose storage.
    localparam int USR_COUNT  = 15;                    // indices 0..14
    localparam int PC_SLOT    = USR_COUNT;             // index 15
    localparam int FIQ_FIRST  = 8;                     // first fiq-private index
    localparam int FIQ_BASE   = PC_SLOT + 1;
    localparam int FIQ_COUNT  = 15 - FIQ_FIRST;        // indices 8..14
    localparam int EXC_FIRST  = 13;                    // first per-mode private index
    localparam int EXC_PER    = 15 - EXC_FIRST;        // indices 13..14
    localparam int EXC_BASE   = FIQ_BASE + FIQ_COUNT;
    localparam int EXC_BANKS  = 4;                     // svc, abt, irq, und
    localparam int NUM_PHYS   = EXC_BASE + EXC_BANKS * EXC_PER;
    localparam int PHYS_W     = $clog2(NUM_PHYS);

    // Status word field positions.
    localparam int PSR_IRQ_DIS = 7;
    localparam int PSR_FIQ_DIS = 6;

    // Translate a mode code into its register bank.
    function automatic bank_e mode_to_bank(input logic [MODE_W-1:0] m);
        case (m)
            MODE_FIQ: return BANK_FIQ;
            MODE_SVC: return BANK_SVC;
            MODE_ABT: return BANK_ABT;
            MODE_IRQ: return BANK_IRQ;
            MODE_UND: return BANK_UND;
            default:  return BANK_USR;
        endcase
    endfunction

endpackage

// File: rtl/bankreg_map.sv
// Maps one architectural index plus a register bank to a physical slot.
// Assumes the layout constants of bankreg_pkg; purely combinational.
module bankreg_map
    import bankreg_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_i,
    input  bank_e             bank_i,
    output logic [PHYS_W-1:0] phys_o
);

    logic [PHYS_W-1:0] exc_group;

    // Offset of the per-mode private pair for non-fast exception banks.
    always_comb begin
        case (bank_i)
            BANK_SVC: exc_group = PHYS_W'(EXC_BASE + 0 * EXC_PER);
            BANK_ABT: exc_group = PHYS_W'(EXC_BASE + 1 * EXC_PER);
            BANK_IRQ: exc_group = PHYS_W'(EXC_BASE + 2 * EXC_PER);
            BANK_UND: exc_group = PHYS_W'(EXC_BASE + 3 * EXC_PER);
            default:  exc_group = '0;
        endcase
    end

    // Select a shared, fast-private or mode-private slot.
    always_comb begin
        if (idx_i == IDX_W'(15)) begin
            phys_o = PHYS_W'(PC_SLOT);
        end else if (bank_i == BANK_FIQ && idx_i >= IDX_W'(FIQ_FIRST)) begin
            phys_o = PHYS_W'(FIQ_BASE) + PHYS_W'(idx_i - IDX_W'(FIQ_FIRST));
        end else if (bank_i != BANK_USR && bank_i != BANK_FIQ
                     && idx_i >= IDX_W'(EXC_FIRST)) begin
            phys_o = exc_group + PHYS_W'(idx_i - IDX_W'(EXC_FIRST));
        end else begin
            phys_o = PHYS_W'(idx_i);
        end
    end

endmodule

// File: rtl/bankreg_gpr_store.sv
// Flat general-purpose storage with NUM_RD combinational read ports and
// one write port committed at the clock edge. Reads see the old value
// during a write cycle. Assumes physical addresses below NUM_ENT.
module bankreg_gpr_store #(
    parameter int DATA_W  = 32,
    parameter int NUM_ENT = 31,
    parameter int NUM_RD  = 2,
    localparam int ADDR_W = $clog2(NUM_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr_i [NUM_RD],
    output logic [DATA_W-1:0] rd_data_o [NUM_RD],
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i
);

    logic [DATA_W-1:0] mem_q [NUM_ENT];

    // Clear on reset, otherwise commit the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < NUM_ENT; e++) begin
                mem_q[e] <= '0;
            end
        end else if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        // Combinational read of the stored entry.
        assign rd_data_o[p] = mem_q[rd_addr_i[p]];
    end

endmodule

// File: rtl/bankreg_psr_store.sv
// Holds the current status word and one saved status word per exception
// bank. The saved word is chosen by the bank of the current mode; the
// user bank has none, so its reads give zero and its writes are dropped.
module bankreg_psr_store
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bank_e             bank_i,
    input  logic              cur_wr_en_i,
    input  logic [DATA_W-1:0] cur_wr_data_i,
    output logic [DATA_W-1:0] cur_o,
    input  logic              sav_wr_en_i,
    input  logic [DATA_W-1:0] sav_wr_data_i,
    output logic [DATA_W-1:0] sav_rd_data_o
);

    localparam int SLOT_W = $clog2(NUM_SAVED);

    localparam logic [DATA_W-1:0] CUR_RESET =
        DATA_W'(MODE_SVC) | (DATA_W'(1) << PSR_IRQ_DIS) | (DATA_W'(1) << PSR_FIQ_DIS);

    logic [DATA_W-1:0] cur_q;
    logic [DATA_W-1:0] sav_q [NUM_SAVED];
    logic              has_saved;
    logic [SLOT_W-1:0] slot;

    // Work out whether the bank owns a saved word and which one.
    always_comb begin
        has_saved = (bank_i != BANK_USR);
        slot      = has_saved ? SLOT_W'(bank_i - BANK_FIQ) : '0;
    end

    // Current status word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= CUR_RESET;
        end else if (cur_wr_en_i) begin
            cur_q <= cur_wr_data_i;
        end
    end

    // Saved status words; writes from a bank without one are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SAVED; s++) begin
                sav_q[s] <= '0;
            end
        end else if (sav_wr_en_i && has_saved) begin
            sav_q[slot] <= sav_wr_data_i;
        end
    end

    assign cur_o         = cur_q;
    assign sav_rd_data_o = has_saved ? sav_q[slot] : '0;

endmodule

// File: rtl/banked_regfile.sv
// Top of the mode-banked register file. Decodes the mode into a bank,
// maps each port index to a physical slot and drives the storage.
// Assumes the core supplies a stable mode for the whole cycle.
module banked_regfile
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode_i,
    input  logic              user_bank_i,
    input  logic [3:0]        rd_a_idx_i,
    output logic [DATA_W-1:0] rd_a_data_o,
    input  logic [3:0]        rd_b_idx_i,
    output logic [DATA_W-1:0] rd_b_data_o,
    input  logic              wr_en_i,
    input  logic [3:0]        wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              cpsr_wr_en_i,
    input  logic [DATA_W-1:0] cpsr_wr_data_i,
    output logic [DATA_W-1:0] cpsr_o,
    input  logic              spsr_wr_en_i,
    input  logic [DATA_W-1:0] spsr_wr_data_i,
    output logic [DATA_W-1:0] spsr_rd_data_o
);

    localparam int NUM_RD   = 2;
    localparam int NUM_PORT = NUM_RD + 1;   // read ports then the write port

    bank_e             mode_bank;
    bank_e             gpr_bank;
    logic [IDX_W-1:0]  port_idx  [NUM_PORT];
    logic [PHYS_W-1:0] port_phys [NUM_PORT];
    logic [PHYS_W-1:0] rd_phys   [NUM_RD];
    logic [DATA_W-1:0] rd_data   [NUM_RD];

    // Bank of the mode, and the bank the general registers use after override.
    always_comb begin
        mode_bank = mode_to_bank(mode_i);
        gpr_bank  = user_bank_i ? BANK_USR : mode_bank;
    end

    assign port_idx[0]        = rd_a_idx_i;
    assign port_idx[1]        = rd_b_idx_i;
    assign port_idx[NUM_RD]   = wr_idx_i;

    for (genvar p = 0; p < NUM_PORT; p++) begin : g_map
        bankreg_map u_map (
            .idx_i  (port_idx[p]),
            .bank_i (gpr_bank),
            .phys_o (port_phys[p])
        );
    end

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rdaddr
        assign rd_phys[r] = port_phys[r];
    end

    bankreg_gpr_store #(
        .DATA_W  (DATA_W),
        .NUM_ENT (NUM_PHYS),
        .NUM_RD  (NUM_RD)
    ) u_gpr (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_i (rd_phys),
        .rd_data_o (rd_data),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (port_phys[NUM_RD]),
        .wr_data_i (wr_data_i)
    );

    assign rd_a_data_o = rd_data[0];
    assign rd_b_data_o = rd_data[1];

    bankreg_psr_store #(
        .DATA_W (DATA_W)
    ) u_psr (
        .clk           (clk),
        .rst_n         (rst_n),
        .bank_i        (mode_bank),
        .cur_wr_en_i   (cpsr_wr_en_i),
        .cur_wr_data_i (cpsr_wr_data_i),
        .cur_o         (cpsr_o),
        .sav_wr_en_i   (spsr_wr_en_i),
        .sav_wr_data_i (spsr_wr_data_i),
        .sav_rd_data_o (spsr_rd_data_o)
    );

endmodule

// File: rtl/banked_regfile_chk.sv
// Port-level temporal checks for banked_regfile, attached by bind.
module banked_regfile_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        mode_i,
    input logic              user_bank_i,
    input logic [3:0]        rd_a_idx_i,
    input logic [DATA_W-1:0] rd_a_data_o,
    input logic [3:0]        rd_b_idx_i,
    input logic [DATA_W-1:0] rd_b_data_o,
    input logic              wr_en_i,
    input logic [3:0]        wr_idx_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic              cpsr_wr_en_i,
    input logic [DATA_W-1:0] cpsr_wr_data_i,
    input logic [DATA_W-1:0] cpsr_o,
    input logic              spsr_wr_en_i,
    input logic [DATA_W-1:0] spsr_wr_data_i,
    input logic [DATA_W-1:0] spsr_rd_data_o
);

    assert_reset_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> cpsr_o == DATA_W'(32'h0000_00D3));

    assert_pc_shared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && wr_idx_i == 4'd15 |=>
        (rd_b_idx_i != 4'd15 || rd_b_data_o == $past(wr_data_i)));

    assert_low_shared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && wr_idx_i < 4'd8 |=>
        (rd_b_idx_i != $past(wr_idx_i) || rd_b_data_o == $past(wr_data_i)));

    assert_no_saved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 5'b10000 || mode_i == 5'b11111) |-> spsr_rd_data_o == '0);

    assert_write_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i && rd_a_idx_i == wr_idx_i |=>
        (!$stable(rd_a_idx_i) || !$stable(mode_i) || !$stable(user_bank_i)
         || rd_a_data_o == $past(wr_data_i)));

    assert_status_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpsr_wr_en_i |=> cpsr_o == $past(cpsr_wr_data_i));

endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_banked_regfile.sv
// Scoreboard bench: driver tasks queue expected values, a monitor compares.
module test_banked_regfile;

    localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                           M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                           M_SYS = 5'b11111, M_BAD = 5'b10100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = M_USR;
    logic        user_bank_i = 1'b0;
    logic [3:0]  rd_a_idx_i = '0, rd_b_idx_i = '0, wr_idx_i = '0;
    logic [31:0] rd_a_data_o, rd_b_data_o, cpsr_o, spsr_rd_data_o;
    logic        wr_en_i = 1'b0, cpsr_wr_en_i = 1'b0, spsr_wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0, cpsr_wr_data_i = '0, spsr_wr_data_i = '0;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    int          q_kind [$];
    logic [31:0] q_exp  [$];
    string       q_tag  [$];

    always #4 clk = ~clk;

    banked_regfile i_banked_regfile (.*);

    // Queue one expected observation for the current cycle.
    task automatic expect_val(input int kind, input logic [31:0] exp, input string tag);
        q_kind.push_back(kind);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    task automatic quiet();
        wr_en_i = 1'b0; cpsr_wr_en_i = 1'b0; spsr_wr_en_i = 1'b0;
    endtask

    task automatic wr_gpr(input logic [4:0] m, input logic ub, input logic [3:0] idx,
                          input logic [31:0] d);
        @(negedge clk);
        quiet();
        mode_i = m; user_bank_i = ub;
        wr_en_i = 1'b1; wr_idx_i = idx; wr_data_i = d;
    endtask

    task automatic rd_chk(input logic [4:0] m, input logic ub,
                          input logic [3:0] ia, input logic [31:0] ea,
                          input logic [3:0] ib, input logic [31:0] eb, input string tag);
        @(negedge clk);
        quiet();
        mode_i = m; user_bank_i = ub; rd_a_idx_i = ia; rd_b_idx_i = ib;
        expect_val(0, ea, tag);
        expect_val(1, eb, tag);
    endtask

    task automatic wr_saved(input logic [4:0] m, input logic [31:0] d);
        @(negedge clk);
        quiet();
        mode_i = m; user_bank_i = 1'b0;
        spsr_wr_en_i = 1'b1; spsr_wr_data_i = d;
    endtask

    task automatic chk_saved(input logic [4:0] m, input logic [31:0] e, input string tag);
        @(negedge clk);
        quiet();
        mode_i = m;
        expect_val(3, e, tag);
    endtask

    // Monitor: compare queued expectations once outputs have settled.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q_kind.size() > 0) begin
                automatic int          k   = q_kind.pop_front();
                automatic logic [31:0] e   = q_exp.pop_front();
                automatic string       t   = q_tag.pop_front();
                automatic logic [31:0] act = (k == 0) ? rd_a_data_o :
                                             (k == 1) ? rd_b_data_o :
                                             (k == 2) ? cpsr_o : spsr_rd_data_o;
                vectors++;
                if (act !== e) begin
                    errors++;
                    $display("FAIL %s port %0d: actual %h expected %h", t, k, act, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        mode_i = M_SVC;
        expect_val(2, 32'h0000_00D3, "R1");
        expect_val(3, 32'h0, "R1");
        rd_chk(M_SVC, 1'b0, 4'd0, 32'h0, 4'd13, 32'h0, "R1");
        rd_chk(M_USR, 1'b0, 4'd15, 32'h0, 4'd14, 32'h0, "R1");

        // Fill the user set, including the program counter.
        for (int i = 0; i < 16; i++) wr_gpr(M_USR, 1'b0, 4'(i), 32'h1000_0000 + 32'(i));

        // R3, R2: shared low registers and program counter seen from fast mode
        for (int i = 0; i < 8; i++)
            rd_chk(M_FIQ, 1'b0, 4'(i), 32'h1000_0000 + 32'(i), 4'd15, 32'h1000_000F, "R3");
        // R4, R5: fast mode private copies start cleared
        for (int i = 8; i < 15; i++)
            rd_chk(M_FIQ, 1'b0, 4'(i), 32'h0, 4'(i), 32'h0, "R4");

        for (int i = 8; i < 15; i++) wr_gpr(M_FIQ, 1'b0, 4'(i), 32'hF000_0000 + 32'(i));
        rd_chk(M_FIQ, 1'b0, 4'd8, 32'hF000_0008, 4'd12, 32'hF000_000C, "R4");
        rd_chk(M_USR, 1'b0, 4'd8, 32'h1000_0008, 4'd12, 32'h1000_000C, "R4");
        rd_chk(M_IRQ, 1'b0, 4'd9, 32'h1000_0009, 4'd11, 32'h1000_000B, "R4");
        rd_chk(M_SYS, 1'b0, 4'd13, 32'h1000_000D, 4'd14, 32'h1000_000E, "R5");

        // R5: private stack and link copies per exception mode
        wr_gpr(M_SVC, 1'b0, 4'd13, 32'h5C00_000D); wr_gpr(M_SVC, 1'b0, 4'd14, 32'h5C00_000E);
        wr_gpr(M_ABT, 1'b0, 4'd13, 32'hAB00_000D); wr_gpr(M_ABT, 1'b0, 4'd14, 32'hAB00_000E);
        wr_gpr(M_IRQ, 1'b0, 4'd13, 32'h1A00_000D); wr_gpr(M_IRQ, 1'b0, 4'd14, 32'h1A00_000E);
        wr_gpr(M_UND, 1'b0, 4'd13, 32'hDD00_000D); wr_gpr(M_UND, 1'b0, 4'd14, 32'hDD00_000E);
        rd_chk(M_SVC, 1'b0, 4'd13, 32'h5C00_000D, 4'd14, 32'h5C00_000E, "R5");
        rd_chk(M_ABT, 1'b0, 4'd13, 32'hAB00_000D, 4'd14, 32'hAB00_000E, "R5");
        rd_chk(M_IRQ, 1'b0, 4'd13, 32'h1A00_000D, 4'd14, 32'h1A00_000E, "R5");
        rd_chk(M_UND, 1'b0, 4'd13, 32'hDD00_000D, 4'd14, 32'hDD00_000E, "R5");
        rd_chk(M_FIQ, 1'b0, 4'd13, 32'hF000_000D, 4'd14, 32'hF000_000E, "R5");
        rd_chk(M_USR, 1'b0, 4'd13, 32'h1000_000D, 4'd14, 32'h1000_000E, "R5");
        rd_chk(M_SVC, 1'b0, 4'd12, 32'h1000_000C, 4'd8, 32'h1000_0008, "R4");

        // R6: user-bank override for reads and writes
        rd_chk(M_FIQ, 1'b1, 4'd8, 32'h1000_0008, 4'd13, 32'h1000_000D, "R6");
        wr_gpr(M_FIQ, 1'b1, 4'd9, 32'hAAAA_0009);
        rd_chk(M_USR, 1'b0, 4'd9, 32'hAAAA_0009, 4'd9, 32'hAAAA_0009, "R6");
        rd_chk(M_FIQ, 1'b0, 4'd9, 32'hF000_0009, 4'd9, 32'hF000_0009, "R6");
        wr_gpr(M_SVC, 1'b1, 4'd14, 32'hBBBB_000E);
        rd_chk(M_USR, 1'b0, 4'd14, 32'hBBBB_000E, 4'd13, 32'h1000_000D, "R6");
        rd_chk(M_SVC, 1'b0, 4'd14, 32'h5C00_000E, 4'd13, 32'h5C00_000D, "R6");

        // R2: program counter written in one mode, read in others
        wr_gpr(M_UND, 1'b0, 4'd15, 32'hC0DE_0015);
        rd_chk(M_USR, 1'b0, 4'd15, 32'hC0DE_0015, 4'd15, 32'hC0DE_0015, "R2");
        rd_chk(M_FIQ, 1'b1, 4'd15, 32'hC0DE_0015, 4'd0, 32'h1000_0000, "R2");

        // R7: saved status words
        wr_saved(M_FIQ, 32'h5A5A_0011); wr_saved(M_IRQ, 32'h5A5A_0012);
        wr_saved(M_SVC, 32'h5A5A_0013); wr_saved(M_ABT, 32'h5A5A_0017);
        wr_saved(M_UND, 32'h5A5A_001B);
        chk_saved(M_FIQ, 32'h5A5A_0011, "R7"); chk_saved(M_IRQ, 32'h5A5A_0012, "R7");
        chk_saved(M_SVC, 32'h5A5A_0013, "R7"); chk_saved(M_ABT, 32'h5A5A_0017, "R7");
        chk_saved(M_UND, 32'h5A5A_001B, "R7");
        wr_saved(M_USR, 32'hDEAD_BEEF);
        chk_saved(M_USR, 32'h0, "R7"); chk_saved(M_SYS, 32'h0, "R7");
        wr_saved(M_SYS, 32'hFEED_F00D);
        chk_saved(M_FIQ, 32'h5A5A_0011, "R7"); chk_saved(M_SVC, 32'h5A5A_0013, "R7");
        chk_saved(M_UND, 32'h5A5A_001B, "R7");

        // R8: same-cycle write and read returns the old value
        @(negedge clk);
        quiet();
        mode_i = M_IRQ; user_bank_i = 1'b0;
        wr_en_i = 1'b1; wr_idx_i = 4'd13; wr_data_i = 32'h7777_000D;
        rd_a_idx_i = 4'd13; rd_b_idx_i = 4'd13;
        expect_val(0, 32'h1A00_000D, "R8");
        expect_val(1, 32'h1A00_000D, "R8");
        rd_chk(M_IRQ, 1'b0, 4'd13, 32'h7777_000D, 4'd3, 32'h1000_0003, "R8");

        // R9: current status write
        @(negedge clk);
        quiet();
        cpsr_wr_en_i = 1'b1; cpsr_wr_data_i = 32'h6000_001F;
        expect_val(2, 32'h0000_00D3, "R9");
        @(negedge clk);
        quiet();
        expect_val(2, 32'h6000_001F, "R9");

        // R10: unlisted encoding behaves as user mode
        rd_chk(M_BAD, 1'b0, 4'd13, 32'h1000_000D, 4'd8, 32'h1000_0008, "R10");
        chk_saved(M_BAD, 32'h0, "R10");
        wr_saved(M_BAD, 32'h1234_5678);
        chk_saved(M_BAD, 32'h0, "R10");
        chk_saved(M_ABT, 32'h5A5A_0017, "R10");

        @(negedge clk);
        quiet();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule